// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a handful of recently used page table entries so that most loads and stores skip the page table read. Each entry pairs a virtual page number tag with a physical page number. An incoming virtual page number is compared against every entry at once. The hit flag, the miss flag and the physical address are purely combinational from the lookup inputs, so a translation completes within the same cycle. The physical address is the matching physical page number with the page offset of the request appended unchanged.

On a miss the surrounding translator reads the page table and then hands the result back through the refill port. A refill first looks for an entry that already holds the same virtual page and updates it in place. If there is none, it fills the lowest-numbered empty entry. When every entry is occupied, it evicts the entry named by a round-robin pointer. A flush input empties the whole buffer in one cycle, for use when the active page table changes on a context switch.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is empty, so any lookup with `lk_valid`=1 gives `lk_miss`=1 and `lk_hit`=0.
- R2: A lookup with `lk_valid`=1 whose page number matches a filled entry gives `lk_hit`=1, `lk_miss`=0 and `lk_paddr` = {stored physical page number, `lk_off`} in the same cycle, with the physical page number in the upper PPN_W bits and the offset in the lower OFF_W bits.
- R3: A lookup with `lk_valid`=1 that matches no filled entry gives `lk_miss`=1 and `lk_hit`=0. With `lk_valid`=0 both flags are 0.
- R4: A refill whose page number is not held by any entry, while at least one entry is empty, writes the lowest-numbered empty entry and leaves every filled entry unchanged.
- R5: A refill of a new page number while all entries are filled replaces the entry named by the round-robin pointer. The pointer is 0 after reset, steps by one after each such eviction, wraps from ENTRIES-1 to 0, and does not move on any other kind of refill.
- R6: A refill whose page number is already held overwrites that entry's physical page number, changes no other entry, and leaves the round-robin pointer where it was.
- R7: A flush empties every entry from the next cycle on. A refill presented in the same cycle as a flush is dropped.
- R8: At no time do two filled entries hold the same page number, so a lookup never matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is being presented |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset, passed through unchanged |
| lk_hit | output | 1 | Lookup matched a filled entry |
| lk_miss | output | 1 | Lookup matched no filled entry |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W | Page number of the translation to write |
| fill_ppn | input | PPN_W | Physical page number of the translation to write |
| flush | input | 1 | Empty every entry |

## Verification
The hardest state to reach is a refill that finds the buffer full with the round-robin pointer at a value other than zero, combined with a refill that updates a page already held. Only a fixed run of refills can line these two events up. The stimulus first fills a four-entry configuration completely, evicts twice to move the pointer, and then updates an entry in place. It then checks that the next eviction still lands on the slot the pointer named before the update. After each step, a sweep of 64 page numbers with offsets derived from them compares every lookup against a model of the entries kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Which way a refill selects its destination entry
  typedef enum logic [1:0] {
    WSEL_NONE  = 2'd0,
    WSEL_DUP   = 2'd1,
    WSEL_FREE  = 2'd2,
    WSEL_EVICT = 2'd3
  } wsel_e;

  // Width of an index into an array of n entries (at least 1)
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15
) (
  input  logic [VPN_W-1:0]                key,
  input  logic [ENTRIES-1:0]              valids,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   tags,
  input  logic [ENTRIES-1:0][PPN_W-1:0]   datas,
  output logic [ENTRIES-1:0]              match,
  output logic                            any,
  output logic [PPN_W-1:0]                data
);
  // One comparator per entry, all in parallel
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valids[i] && (tags[i] == key);
  end

  assign any = |match;

  // AND-OR select: at most one match bit is set
  always_comb begin
    data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) data = data | datas[i];
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  localparam int PW = idx_width(ENTRIES)
) (
  input  logic               req,
  input  logic [ENTRIES-1:0] valids,
  input  logic [ENTRIES-1:0] dup,
  input  logic [PW-1:0]      ptr,
  output logic [ENTRIES-1:0] sel,
  output wsel_e              kind
);
  logic [PW-1:0] free_idx;
  logic          have_free;

  // Lowest-numbered empty entry
  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valids[i]) begin
        free_idx  = PW'(i);
        have_free = 1'b1;
      end
    end
  end

  // Priority: in-place update, then empty slot, then round-robin eviction
  always_comb begin
    sel  = '0;
    kind = WSEL_NONE;
    if (req) begin
      if (|dup) begin
        sel  = dup;
        kind = WSEL_DUP;
      end else if (have_free) begin
        sel[free_idx] = 1'b1;
        kind          = WSEL_FREE;
      end else begin
        sel[ptr] = 1'b1;
        kind     = WSEL_EVICT;
      end
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15,
  parameter int OFF_W   = 12,
  localparam int PW     = idx_width(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);
  // Entry storage kept in flops so that flush can clear every valid bit at once
  logic [ENTRIES-1:0]            ent_v;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [PW-1:0]                 rr_ptr;

  logic [ENTRIES-1:0] lk_match, fill_match, wr_sel;
  logic               lk_any, fill_any;
  logic [PPN_W-1:0]   lk_ppn, fill_old_ppn;
  logic               fill_go;
  wsel_e              wr_kind;

  assign fill_go = fill_en && !flush;

  xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_lk_cam (
    .key(lk_vpn), .valids(ent_v), .tags(ent_tag), .datas(ent_ppn),
    .match(lk_match), .any(lk_any), .data(lk_ppn)
  );

  xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_fill_cam (
    .key(fill_vpn), .valids(ent_v), .tags(ent_tag), .datas(ent_ppn),
    .match(fill_match), .any(fill_any), .data(fill_old_ppn)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .req(fill_go), .valids(ent_v), .dup(fill_match), .ptr(rr_ptr),
    .sel(wr_sel), .kind(wr_kind)
  );

  // Combinational lookup result
  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_paddr = {lk_ppn, lk_off};

  // Valid bits and victim pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v  <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      ent_v  <= '0;
    end else begin
      ent_v <= ent_v | wr_sel;
      if (wr_kind == WSEL_EVICT) begin
        rr_ptr <= (rr_ptr == PW'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  // Tag and data payload, no reset needed
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_sel[i]) begin
        ent_tag[i] <= fill_vpn;
        ent_ppn[i] <= fill_ppn;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (ent_v == '0)); // R1

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss) && ((lk_hit || lk_miss) == lk_valid)); // R3

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_v == '0)); // R7

  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> (ent_v != '0)); // R4

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match) && $onehot0(fill_match)); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_kind != WSEL_EVICT) |=> $stable(rr_ptr)); // R5

  AST_DUP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (fill_go && fill_any) |=> ($countones(ent_v) == $countones($past(ent_v)))); // R6

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    rr_ptr <= PW'(ENTRIES - 1)); // R5

  logic unused_ok;
  assign unused_ok = ^fill_old_ppn;
endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;
  localparam int N     = 4;
  localparam int VPN_W = 19;
  localparam int PPN_W = 15;
  localparam int OFF_W = 12;
  localparam int PA_W  = PPN_W + OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic lk_hit, lk_miss;
  logic [PA_W-1:0] lk_paddr;
  logic fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the entries
  bit               m_v   [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PPN_W-1:0] m_ppn [N];
  int               m_ptr;

  always #5 clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model of a refill following R4, R5, R6
  task automatic model_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
    int slot = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) slot = i;
    if (slot < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_v[slot] = 1'b1; m_vpn[slot] = v; m_ppn[slot] = p;
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input bit with_flush);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; flush = with_flush;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
    if (with_flush) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    else model_fill(v, p);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o, input string req);
    int slot = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) slot = i;
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_off = o;
    #2;
    check(req, {62'd0, lk_hit, lk_miss}, (slot >= 0) ? 64'd2 : 64'd1);
    if (slot >= 0) check(req, 64'(lk_paddr), 64'({m_ppn[slot], o}));
    lk_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 64; v++) look(VPN_W'(v), OFF_W'((v * 37 + 5) & 12'hFFF), req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look(19'h10, 12'h123, "R1");
    sweep("R1");

    // R3: no lookup presented -> both flags low
    @(negedge clk); lk_valid = 1'b0; lk_vpn = 19'h10; #2;
    check("R3", {62'd0, lk_hit, lk_miss}, 64'd0);

    // R4: fill four empty slots in order
    for (int i = 0; i < 4; i++) do_fill(VPN_W'(16 + i), PPN_W'(16'h100 + i), 1'b0);
    sweep("R2");
    look(19'h7FFFF, 12'hFFF, "R3");
    look(19'h10, 12'hFFF, "R2");
    look(19'h13, 12'h000, "R2");

    // R5: two evictions at pointer 0 then 1
    do_fill(19'h20, 15'h7ABC, 1'b0);
    look(19'h10, 12'h0, "R5");
    sweep("R5");
    do_fill(19'h21, 15'h0001, 1'b0);
    look(19'h11, 12'h0, "R5");
    sweep("R5");

    // R6: in-place update of 0x12, pointer stays at 2
    do_fill(19'h12, 15'h0007, 1'b0);
    look(19'h12, 12'hABC, "R6");
    sweep("R6");
    do_fill(19'h22, 15'h0055, 1'b0);   // evicts slot 2 (0x12)
    look(19'h12, 12'h0, "R6");
    look(19'h13, 12'h1, "R6");
    sweep("R8");
    do_fill(19'h23, 15'h0066, 1'b0);   // evicts slot 3 (0x13)
    do_fill(19'h24, 15'h0077, 1'b0);   // wraps, evicts slot 0 (0x20)
    look(19'h20, 12'h0, "R5");
    sweep("R5");

    // R7: flush empties everything
    do_flush();
    sweep("R7");
    // R7: refill concurrent with flush is dropped
    do_fill(19'h30, 15'h0123, 1'b0);
    do_fill(19'h31, 15'h0456, 1'b1);
    look(19'h31, 12'h0, "R7");
    look(19'h30, 12'h0, "R7");
    // R4 after flush: lowest empty slot refilled, other pages coexist
    do_fill(19'h32, 15'h0789, 1'b0);
    do_fill(19'h33, 15'h0AAA, 1'b0);
    sweep("R4");

    // R1: reset mid-run clears contents
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
    look(19'h32, 12'h0, "R1");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule